// File: doc/BRIEF.md
# Fast Page DRAM Strobe Sequencer

This block sits between a simple request port and an asynchronous dynamic memory that takes its row and its column over the same address pins. For each host read or write it produces the row strobe, the four per-bit column strobes, write enable, output enable and the data-bus drive. Every phase length is a parameter counted in clock cycles.

After an access the row stays open. A later request to the same row runs as a short column-only cycle. A request to another row closes the current row, waits out the precharge time and then opens the new row. The row strobe is never held low longer than the page-mode limit. When that limit comes near, the row is closed even if a same-row request is waiting.

A separate refresh scheduler asks for the device with a request line. The sequencer first finishes the access in progress, closes the row and lets precharge elapse. It then raises a grant and keeps every strobe inactive until the request is withdrawn. The data bus is split into out, enable and in signals, so the tristate buffer sits in the pad ring.

Top module: `fpdram_sequencer`

## Requirements
- R1: When the row strobe falls, `dram_addr` carries the row (request address bits [21:10]) and keeps it on the next cycle. When a column strobe falls, `dram_addr[9:0]` carries the column (request address bits [9:0]).
- R2: A column strobe is low only while the row strobe is low. The first column strobe falls no earlier than T_RCD cycles after the row strobe falls.
- R3: Between a rise of the row strobe and its next fall, the row strobe stays high for at least T_RP cycles.
- R4: Each low period of the row strobe lasts at least T_RAS_MIN cycles.
- R5: No low period of the row strobe exceeds T_RASP_MAX cycles. An open row that gets no further same-row traffic is closed before that limit.
- R6: On a write, `dram_we_n` is low and the data bus is driven for at least one cycle before any column strobe falls. `dram_oe_n` stays high. Column strobe i falls only where `req_mask[i]` is 1, and that strobe writes `req_wdata[i]` into bit i.
- R7: On a read, all four column strobes fall together with `dram_oe_n` low, `dram_we_n` high and the bus not driven. The value on `dram_dq_in` during the last column-strobe-low cycle is returned on `rd_data`.
- R8: `rd_valid` is a single-cycle pulse. It is high in the cycle right after the last column-strobe-low cycle of a read, which is the cycle in which the strobes return high.
- R9: A request to the open row is served without toggling the row strobe. A request to another row causes exactly one new row activation.
- R10: While `ref_req` is high, no host request is accepted. `ref_gnt` rises only after the row has been closed for at least T_RP cycles and all reads have returned. While `ref_gnt` is high, all strobes are high. `ref_gnt` stays high until `ref_req` falls.
- R11: During and right after reset, all strobes and `dram_we_n`/`dram_oe_n` are high, the bus is not driven, and `rd_valid` and `ref_gnt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | DQ_W | Per-bit write enable |
| req_wdata | input | DQ_W | Write data |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | DQ_W | Read data |
| ref_req | input | 1 | Refresh scheduler wants the device |
| ref_gnt | output | 1 | Device idle and precharged, handed to refresh |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | DQ_W | Column strobes, one per data bit, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DQ_W | Data driven to the memory |
| dram_dq_oe | output | 1 | Drive enable for the data bus |
| dram_dq_in | input | DQ_W | Data returned by the memory |

## Verification
The bench watches the strobes cycle by cycle against a behavioural memory. It targets the tight limits first. A sequencer that rises the row strobe too early trips the minimum low width. A sequencer that skips the precharge count reopens a row too soon. A sequencer that admits a page cycle near the limit stretches the low period past T_RASP_MAX.

Masked writes followed by read-back expose strobes mapped to the wrong bits, and a read sampled one cycle off returns stale data. Activation counts across same-row and other-row pairs catch a design that reopens on every access or never closes. Refresh raised during an access catches a grant given with the row still open or with a read still pending.

// File: rtl/fpdram_pkg.sv
package fpdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // row closed, precharged
    ST_PRECH,  // row strobe high, counting precharge
    ST_ACT,    // row strobe low, row address held
    ST_COLA,   // column address, write data and enable set up
    ST_CASL,   // column strobes low
    ST_OPEN,   // row open, strobes high, waiting
    ST_GRANT   // device handed to refresh
  } seq_state_t;

  function automatic int fpdram_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpdram_phase_timer.sv
module fpdram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (load)     cnt_q <= value;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/fpdram_low_counter.sv
module fpdram_low_counter #(
  parameter int W   = 16,
  parameter int SAT = 10000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe_low,
  output logic [W-1:0] cycles
);
  always_ff @(posedge clk) begin
    if (rst || !strobe_low)       cycles <= '0;
    else if (cycles != W'(SAT))   cycles <= cycles + 1'b1;
  end
endmodule

// File: rtl/fpdram_sequencer.sv
module fpdram_sequencer import fpdram_pkg::*; #(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 10,
  parameter int DQ_W       = 4,
  parameter int T_RP       = 4,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 3,
  parameter int T_RAS_MIN  = 6,
  parameter int T_RASP_MAX = 10000
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [ROW_W+COL_W-1:0]                 req_addr,
  input  logic                                   req_write,
  input  logic [DQ_W-1:0]                        req_mask,
  input  logic [DQ_W-1:0]                        req_wdata,
  output logic                                   rd_valid,
  output logic [DQ_W-1:0]                        rd_data,
  input  logic                                   ref_req,
  output logic                                   ref_gnt,
  output logic [fpdram_max(ROW_W,COL_W)-1:0]     dram_addr,
  output logic                                   dram_ras_n,
  output logic [DQ_W-1:0]                        dram_cas_n,
  output logic                                   dram_we_n,
  output logic                                   dram_oe_n,
  output logic [DQ_W-1:0]                        dram_dq_out,
  output logic                                   dram_dq_oe,
  input  logic [DQ_W-1:0]                        dram_dq_in
);
  localparam int ADDR_W    = ROW_W + COL_W;
  localparam int MUX_W     = fpdram_max(ROW_W, COL_W);
  localparam int STEP_MAX  = fpdram_max(fpdram_max(T_RP, T_RCD), T_CAS);
  localparam int TMR_W     = $clog2(STEP_MAX + 1);
  localparam int RAS_W     = $clog2(T_RASP_MAX + 1) + 1;
  localparam int PAGE_SPAN = T_CAS + 3;  // low cycles a page cycle adds before the next close point

  seq_state_t state, state_d;
  logic [ROW_W-1:0] open_row, nx_row;
  logic [COL_W-1:0] cur_col, nx_col;
  logic             cur_write, nx_write;
  logic [DQ_W-1:0]  cur_mask, nx_mask, cur_wdata, nx_wdata, cas_fall;
  logic             tmr_load, tmr_zero, accept, row_hit, page_ok, ras_ok;
  logic [TMR_W-1:0] tmr_val;
  logic [RAS_W-1:0] ras_cnt;

  fpdram_phase_timer #(.W(TMR_W)) i_phase (
    .clk(clk), .rst(rst), .load(tmr_load), .value(tmr_val), .zero(tmr_zero));

  fpdram_low_counter #(.W(RAS_W), .SAT(T_RASP_MAX)) i_ras_low (
    .clk(clk), .rst(rst), .strobe_low(!dram_ras_n), .cycles(ras_cnt));

  assign row_hit = (req_addr[ADDR_W-1:COL_W] == open_row);
  assign page_ok = (ras_cnt + RAS_W'(PAGE_SPAN)) <= RAS_W'(T_RASP_MAX);
  assign ras_ok  = (ras_cnt + 1'b1) >= RAS_W'(T_RAS_MIN);

  assign req_ready = !ref_req &&
                     ((state == ST_IDLE) || (state == ST_OPEN && row_hit && page_ok));
  assign accept    = req_valid && req_ready;

  // next access fields as they will be after this edge
  assign nx_row   = (accept && state == ST_IDLE) ? req_addr[ADDR_W-1:COL_W] : open_row;
  assign nx_col   = accept ? req_addr[COL_W-1:0] : cur_col;
  assign nx_write = accept ? req_write : cur_write;
  assign nx_mask  = accept ? req_mask  : cur_mask;
  assign nx_wdata = accept ? req_wdata : cur_wdata;

  // per-bit strobe selection: reads fire every bit, writes only masked bits
  for (genvar b = 0; b < DQ_W; b++) begin : g_strobe
    assign cas_fall[b] = !nx_write || nx_mask[b];
  end

  always_comb begin
    state_d  = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: begin
        if (ref_req) state_d = ST_GRANT;
        else if (accept) begin
          state_d = ST_ACT; tmr_load = 1'b1; tmr_val = TMR_W'(T_RCD - 1);
        end
      end
      ST_PRECH: if (tmr_zero) state_d = ST_IDLE;
      ST_ACT:   if (tmr_zero) state_d = ST_COLA;
      ST_COLA: begin
        state_d = ST_CASL; tmr_load = 1'b1; tmr_val = TMR_W'(T_CAS - 1);
      end
      ST_CASL:  if (tmr_zero) state_d = ST_OPEN;
      ST_OPEN: begin
        if (accept) state_d = ST_COLA;
        else if ((ref_req || req_valid || !page_ok) && ras_ok) begin
          state_d = ST_PRECH; tmr_load = 1'b1; tmr_val = TMR_W'(T_RP - 1);
        end
      end
      ST_GRANT: begin
        if (!ref_req) begin
          state_d = ST_PRECH; tmr_load = 1'b1; tmr_val = TMR_W'(T_RP - 1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      open_row    <= '0;
      cur_col     <= '0;
      cur_write   <= 1'b0;
      cur_mask    <= '0;
      cur_wdata   <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= '1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      ref_gnt     <= 1'b0;
    end else begin
      state     <= state_d;
      open_row  <= nx_row;
      cur_col   <= nx_col;
      cur_write <= nx_write;
      cur_mask  <= nx_mask;
      cur_wdata <= nx_wdata;
      ref_gnt   <= (state_d == ST_GRANT);
      rd_valid  <= (state == ST_CASL) && tmr_zero && !cur_write;
      if ((state == ST_CASL) && tmr_zero && !cur_write) rd_data <= dram_dq_in;

      unique case (state_d)
        ST_ACT: begin
          dram_ras_n <= 1'b0; dram_addr <= MUX_W'(nx_row);
          dram_cas_n <= '1;   dram_we_n <= 1'b1; dram_oe_n <= 1'b1; dram_dq_oe <= 1'b0;
        end
        ST_COLA: begin
          dram_ras_n  <= 1'b0; dram_addr <= MUX_W'(nx_col); dram_cas_n <= '1;
          dram_we_n   <= !nx_write; dram_oe_n <= 1'b1;
          dram_dq_oe  <= nx_write;  dram_dq_out <= nx_wdata;
        end
        ST_CASL: begin
          dram_ras_n <= 1'b0;
          dram_cas_n <= ~cas_fall;
          dram_oe_n  <= nx_write;
        end
        ST_OPEN: begin
          dram_ras_n <= 1'b0; dram_cas_n <= '1;
          dram_we_n  <= 1'b1; dram_oe_n  <= 1'b1; dram_dq_oe <= 1'b0;
        end
        default: begin
          dram_ras_n <= 1'b1; dram_cas_n <= '1;
          dram_we_n  <= 1'b1; dram_oe_n  <= 1'b1; dram_dq_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fpdram_sva.sv
module fpdram_sva #(
  parameter int DQ_W       = 4,
  parameter int MUX_W      = 12,
  parameter int T_RP       = 4,
  parameter int T_RAS_MIN  = 6,
  parameter int T_RASP_MAX = 10000
) (
  input logic             clk,
  input logic             rst,
  input logic             ras_n,
  input logic [DQ_W-1:0]  cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic [MUX_W-1:0] addr,
  input logic             rd_valid,
  input logic             ref_gnt
);
  int hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= T_RP;
      lo_cnt <= 0;
    end else begin
      hi_cnt <= ras_n  ? ((hi_cnt > T_RP) ? hi_cnt : hi_cnt + 1) : 0;
      lo_cnt <= !ras_n ? ((lo_cnt > T_RASP_MAX) ? lo_cnt : lo_cnt + 1) : 0;
    end
  end

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |=> $stable(addr));                                   // R1
  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (rst)
    (cas_n != '1) |-> !ras_n);                                         // R2
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_cnt >= T_RP));                                // R3
  AST_RAS_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (lo_cnt >= T_RAS_MIN));                           // R4
  AST_RAS_MAX: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> (lo_cnt < T_RASP_MAX));                                 // R5
  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    ((cas_n != '1) && ($past(cas_n) == '1) && !we_n) |->
      (!$past(we_n) && $past(dq_oe) && oe_n));                         // R6
  AST_READ_BUS: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (!dq_oe && we_n));                                       // R7
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);                                           // R8
  AST_GNT_QUIET: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |-> (ras_n && (cas_n == '1)));                             // R10
endmodule

bind fpdram_sequencer fpdram_sva #(
  .DQ_W(DQ_W), .MUX_W(MUX_W), .T_RP(T_RP),
  .T_RAS_MIN(T_RAS_MIN), .T_RASP_MAX(T_RASP_MAX)
) i_fpdram_sva (
  .clk(clk), .rst(rst), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe),
  .addr(dram_addr), .rd_valid(rd_valid), .ref_gnt(ref_gnt)
);

// File: tb/test_fpdram_sequencer.sv
module test_fpdram_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 12, COL_W = 10, DQ_W = 4;
  localparam int T_RP = 4, T_RCD = 2, T_CAS = 3, T_RAS_MIN = 9, T_RASP_MAX = 30;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0] req_mask = '0, req_wdata = '0, rd_data;
  logic rd_valid, ref_req = 1'b0, ref_gnt;
  logic [11:0] dram_addr;
  logic dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [3:0] dram_cas_n, dram_dq_out, dram_dq_in = '0;

  fpdram_sequencer #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS_MIN(T_RAS_MIN), .T_RASP_MAX(T_RASP_MAX))
  i_fpdram_sequencer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_mask(req_mask),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_err = 0, ras_falls = 0;
  bit done = 1'b0;
  logic [3:0] mem    [int unsigned];
  logic [3:0] shadow [int unsigned];
  logic [3:0] exp_q[$];
  logic [11:0] cur_row; logic [9:0] cur_col; logic cur_wr; logic [3:0] cur_mask, cur_data;

  function automatic logic [3:0] init_val(input logic [21:0] a);
    return a[3:0] ^ a[11:8] ^ a[21:18] ^ 4'h9;
  endfunction
  function automatic logic [3:0] mem_get(input logic [21:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : init_val(a);
  endfunction
  function automatic logic [3:0] shadow_get(input logic [21:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural memory and cycle-level protocol monitor
  logic p_ras = 1'b1, p_we = 1'b1, p_dqoe = 1'b0, p_rdv = 1'b0, p_gnt = 1'b0;
  logic [3:0] p_cas = 4'hF;
  logic [11:0] row_l; logic [9:0] col_l;
  int hi = T_RP, lo = 0, since = 0;
  bit row_chk = 1'b0, lo_flag = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!dram_ras_n && p_ras) begin
        check(hi >= T_RP, "R3 precharge", hi, T_RP);
        check(dram_addr == cur_row, "R1 row address", dram_addr, cur_row);
        row_l = dram_addr; since = 0; lo = 1; lo_flag = 0; row_chk = 1; ras_falls++;
      end else if (!dram_ras_n) begin
        lo++; since++;
        if (row_chk) begin
          check(dram_addr == row_l, "R1 row hold", dram_addr, row_l); row_chk = 0;
        end
        if (lo > T_RASP_MAX && !lo_flag) begin
          check(0, "R5 ras low too long", lo, T_RASP_MAX); lo_flag = 1;
        end
      end
      if (dram_ras_n && !p_ras) begin
        check(lo >= T_RAS_MIN, "R4 ras min", lo, T_RAS_MIN);
        check(lo <= T_RASP_MAX, "R5 ras max", lo, T_RASP_MAX);
        hi = 1;
      end else if (dram_ras_n && hi < 1000) hi++;

      if (dram_cas_n != 4'hF && dram_ras_n) check(0, "R2 cas with row closed", dram_cas_n, 4'hF);
      if (dram_cas_n != 4'hF && p_cas == 4'hF) begin
        col_l = dram_addr[9:0];
        check(since >= T_RCD, "R2 ras to cas", since, T_RCD);
        check(dram_addr[9:0] == cur_col, "R1 column address", dram_addr[9:0], cur_col);
        if (!dram_we_n) begin
          check(!p_we && p_dqoe && dram_oe_n, "R6 early write setup", {p_we, p_dqoe, dram_oe_n}, 3'b011);
          check(dram_cas_n == ~cur_mask, "R6 strobe mask", dram_cas_n, ~cur_mask);
          check(dram_dq_out == cur_data, "R6 write data", dram_dq_out, cur_data);
        end else begin
          check(dram_cas_n == 4'h0 && !dram_oe_n && !dram_dq_oe, "R7 read strobes",
                {dram_cas_n, dram_oe_n, dram_dq_oe}, 6'h0);
        end
      end
      for (int i = 0; i < 4; i++) begin
        if (!dram_cas_n[i] && p_cas[i] && !dram_we_n) begin
          logic [3:0] t;
          t = mem_get({row_l, dram_addr[9:0]});
          t[i] = dram_dq_out[i];
          mem[int'({row_l, dram_addr[9:0]})] = t;
        end
      end
      dram_dq_in <= (dram_cas_n != 4'hF && !dram_oe_n && dram_we_n) ? mem_get({row_l, col_l}) : 4'h0;

      if (rd_valid) begin
        check(!p_rdv, "R8 single pulse", p_rdv, 0);
        check(p_cas == 4'h0 && dram_cas_n == 4'hF, "R8 pulse timing", {p_cas, dram_cas_n}, 8'h0F);
        if (exp_q.size() == 0) check(0, "R7 unexpected read data", rd_data, 0);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R7 read data", rd_data, e);
        end
      end
      if (ref_gnt) check(dram_ras_n && dram_cas_n == 4'hF, "R10 strobes parked", {dram_ras_n, dram_cas_n}, 5'h1F);
      if (ref_gnt && !p_gnt) begin
        check(hi >= T_RP, "R10 precharged before grant", hi, T_RP);
        check(exp_q.size() == 0, "R10 reads done before grant", exp_q.size(), 0);
      end
      if (p_gnt && !ref_gnt) check(!ref_req, "R10 grant held", ref_req, 0);
      if (ref_req && req_valid) check(!req_ready, "R10 no accept in refresh", req_ready, 0);
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_dqoe = dram_dq_oe;
      p_rdv = rd_valid; p_gnt = ref_gnt;
    end
  end

  task automatic issue(input logic [21:0] a, input logic w, input logic [3:0] m, input logic [3:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_write = w; req_mask = m; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    cur_row = a[21:10]; cur_col = a[9:0]; cur_wr = w; cur_mask = m; cur_data = d;
    if (w) begin
      logic [3:0] t;
      t = shadow_get(a);
      for (int i = 0; i < 4; i++) if (m[i]) t[i] = d[i];
      shadow[int'(a)] = t;
    end else exp_q.push_back(shadow_get(a));
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_refresh(input int hold);
    @(posedge clk); #1; ref_req = 1'b1;
    forever begin @(negedge clk); if (ref_gnt) break; end
    repeat (hold) @(posedge clk);
    #1; ref_req = 1'b0;
    forever begin @(negedge clk); if (!ref_gnt) break; end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_err++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    finish_run();
  end

  initial begin
    int f0;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dram_ras_n && dram_cas_n == 4'hF && dram_we_n && dram_oe_n && !dram_dq_oe &&
          !rd_valid && !ref_gnt, "R11 reset state", {dram_ras_n, dram_cas_n}, 5'h1F);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(dram_ras_n && dram_cas_n == 4'hF && !dram_dq_oe && !ref_gnt, "R11 after reset",
          {dram_ras_n, dram_cas_n}, 5'h1F);

    // R9 page hit then row miss
    f0 = ras_falls;
    issue({12'h005, 10'h001}, 1'b1, 4'hF, 4'h5);
    issue({12'h005, 10'h001}, 1'b0, 4'h0, 4'h0);
    drain();
    check(ras_falls - f0 == 1, "R9 page hit no reopen", ras_falls - f0, 1);
    issue({12'h006, 10'h001}, 1'b1, 4'h5, 4'hA);
    drain();
    check(ras_falls - f0 == 2, "R9 row miss reopen", ras_falls - f0, 2);
    issue({12'h005, 10'h001}, 1'b0, 4'h0, 4'h0);
    issue({12'h006, 10'h001}, 1'b0, 4'h0, 4'h0);
    drain();
    check(ras_falls - f0 == 4, "R9 alternating rows", ras_falls - f0, 4);
    // R6 masked write over known value
    issue({12'h005, 10'h003}, 1'b1, 4'hF, 4'h0);
    issue({12'h005, 10'h003}, 1'b1, 4'h6, 4'hF);
    issue({12'h005, 10'h003}, 1'b0, 4'h0, 4'h0);
    drain();
    // R5 idle open row must close
    repeat (T_RASP_MAX + 5) @(negedge clk);
    check(dram_ras_n, "R5 idle row closed", dram_ras_n, 1);
    // R10 refresh raised behind a read
    issue({12'h007, 10'h00F}, 1'b0, 4'h0, 4'h0);
    do_refresh(3);
    drain();

    fork
      begin
        for (int n = 0; n < 300; n++) begin
          logic [21:0] a;
          a = {12'(($urandom % 3) + 5), 10'($urandom % 16)};
          issue(a, 1'($urandom), 4'($urandom), 4'($urandom));
        end
      end
      begin
        for (int k = 0; k < 12; k++) begin
          repeat (($urandom % 200) + 20) @(posedge clk);
          do_refresh(($urandom % 4) + 1);
        end
      end
    join
    drain();
    finish_run();
  end
endmodule